// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. Its one data bus can carry a read transfer and a write transfer in alternating clocks with no idle cycle between them. Every control input is captured on the rising clock. A clock-enable input turns a rising edge into an ignored edge. A sleep input freezes the whole device.

The store is a parameterized word array. Each word is split into byte lanes of eight data bits plus one parity bit. A command is either a new operation at an external address or a continuation of a four-beat burst. A burst walks through its low address bits in either linear or interleaved order. Write data arrives on the bus one bus slot after the command. For that reason the write address and lane mask are held in a two-stage registry. A read that hits a write still in the registry gets the bus data forwarded, lane by lane. The data port is modelled as separate in and out vectors plus a drive enable, which stands for the tri-state control of a shared bus.

Top module: `zt_sram`

## Requirements
- R1: After reset is released, qDrive is low until a read reaches its bus slot.
- R2: A new read is a sampled edge with ceN low, ce2 high, ce2N low, advLd low (0 = load, 1 = advance), weN high and ckeN low, and it uses addr. Its word is on qOut with qDrive high from the first active edge after the command until the second active edge.
- R3: A new write is a selected load edge with weN low and at least one bwN bit low. dIn is sampled at the second active edge after the command. Lane i is bits [9i+8:9i], and it is written only when bwN[i] was low on the command edge.
- R4: A write command with every bwN bit high leaves every word unchanged and does not drive the bus.
- R5: With advLd high, the previous operation repeats at the next burst address, and the chip enables and weN are not looked at. The upper address bits stay fixed. For beat n of the burst, the low two bits become start+n mod 4 when seqLinear is 1 and start XOR n when seqLinear is 0.
- R6: A load edge with any chip enable inactive deselects the device. Later advance edges keep it deselected, and the bus slots that belong to these edges are not driven.
- R7: An edge with ckeN high changes no state, performs no write and does not count toward any pipeline delay. A driven read word stays driven, and an undriven write slot stays undriven.
- R8: While oeN is high, qDrive is low, with no clock edge needed.
- R9: A read whose address matches a write that is still pending returns the new lanes of that write and the old contents of the other lanes.
- R10: While sleep is high, edges are ignored, every stored word and every pipeline register keeps its value, and qDrive is low.
- R11: Reads and writes can alternate on consecutive active edges with no idle cycle, and every transfer still lands correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | ADDR_W | Word address for a load command |
| ceN | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2N | input | 1 | Chip enable, active low |
| advLd | input | 1 | 0 loads a new command, 1 advances the burst |
| weN | input | 1 | 0 selects write on a load command |
| bwN | input | LANES | Active-low lane write enables |
| ckeN | input | 1 | 1 makes the edge an ignored edge |
| oeN | input | 1 | Asynchronous output enable, active low |
| seqLinear | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Freezes the device while high |
| dIn | input | LANES*LANE_W | Write data from the bus |
| qOut | output | LANES*LANE_W | Read data register |
| qDrive | output | 1 | Bus drive enable for qOut |

## Verification
The properties assume that all inputs change only away from the rising edge. They also assume that oeN and sleep are steady across an edge at which a rise of qDrive is judged. The bench drives every input at the falling edge, so each value is stable over the rising edge that samples it. It changes oeN only outside the checked windows and enters sleep only after deselect edges. The sweeps cover every word of the small array, every lane mask, both burst orders at every start offset, and stalls placed during read slots and during write slots.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Strobes from control to datapath, valid for the current active edge.
  typedef struct packed {
    logic commit;  // oldest registry entry writes the array from dIn
    logic load;    // output register takes the read word
    logic drop;    // output register goes invalid
  } strobe_s;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              advLd,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              ckeN,
  input  logic              sleep,
  input  logic              seqLinear,
  output strobe_s           stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrMask
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              act, sel;
  op_e               lastOp, cmdOp, op1, op2;
  logic [ADDR_W-1:0] baseQ, cmdAddr, a1, a2;
  logic [BURST_W-1:0] cntQ, cntNext, lowBits;
  logic [LANES-1:0]  cmdMask, m1, m2;

  assign act = !ckeN && !sleep;
  assign sel = !ceN && ce2 && !ce2N;

  always_comb begin
    cntNext = advLd ? cntQ + 1'b1 : '0;
    lowBits = seqLinear ? baseQ[BURST_W-1:0] + cntNext
                        : baseQ[BURST_W-1:0] ^ cntNext;
    if (advLd) begin
      cmdOp   = lastOp;
      cmdAddr = {baseQ[ADDR_W-1 -: HI_W], lowBits};
    end else begin
      cmdOp   = !sel ? OP_NONE : (weN ? OP_READ : OP_WRITE);
      cmdAddr = addr;
    end
    cmdMask = (cmdOp == OP_WRITE) ? ~bwN : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOp <= OP_NONE;
      op1    <= OP_NONE;
      op2    <= OP_NONE;
      baseQ  <= '0;
      cntQ   <= '0;
      a1     <= '0;
      a2     <= '0;
      m1     <= '0;
      m2     <= '0;
    end else if (act) begin
      lastOp <= cmdOp;
      cntQ   <= cntNext;
      if (!advLd) baseQ <= addr;
      op1    <= cmdOp;
      a1     <= cmdAddr;
      m1     <= cmdMask;
      op2    <= op1;
      a2     <= a1;
      m2     <= m1;
    end
  end

  assign stb.commit = act && (op2 == OP_WRITE);
  assign stb.load   = act && (op1 == OP_READ);
  assign stb.drop   = act && (op1 != OP_READ);
  assign rdAddr     = a1;
  assign wrAddr     = a2;
  assign wrMask     = m2;
endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_s           stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LANES-1:0]  wrMask,
  input  logic [DATA_W-1:0] dIn,
  input  logic              oeN,
  input  logic              sleep,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord, outQ;
  logic              outValid, hit;

  // Forward the lanes of the write committing on this edge into the read.
  always_comb begin
    rdWord = mem[rdAddr];
    hit    = stb.commit && (wrAddr == rdAddr);
    for (int i = 0; i < LANES; i++) begin
      if (hit && wrMask[i]) rdWord[i*LANE_W +: LANE_W] = dIn[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrMask[i]) mem[wrAddr][i*LANE_W +: LANE_W] <= dIn[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ     <= '0;
      outValid <= 1'b0;
    end else if (stb.load) begin
      outQ     <= rdWord;
      outValid <= 1'b1;
    end else if (stb.drop) begin
      outValid <= 1'b0;
    end
  end

  assign qOut   = outQ;
  assign qDrive = outValid && !oeN && !sleep;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              advLd,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              ckeN,
  input  logic              oeN,
  input  logic              seqLinear,
  input  logic              sleep,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive
);
  strobe_s           stb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [LANES-1:0]  wrMask;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .ce2(ce2), .ce2N(ce2N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .ckeN(ckeN), .sleep(sleep),
    .seqLinear(seqLinear), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrMask(wrMask)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrMask(wrMask), .dIn(dIn), .oeN(oeN), .sleep(sleep), .qOut(qOut),
    .qDrive(qDrive)
  );
endmodule

// File: rtl/zt_sram_check.sv
module zt_sram_check #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              ce2,
  input logic              ce2N,
  input logic              advLd,
  input logic              weN,
  input logic              ckeN,
  input logic              oeN,
  input logic              sleep,
  input logic              qDrive,
  input logic [DATA_W-1:0] qOut
);
  logic act, sel;
  assign act = !ckeN && !sleep;
  assign sel = !ceN && ce2 && !ce2N;

  // Ignored and sleeping edges leave the read register untouched.
  assert_ignored_edge_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ckeN || sleep) |=> $stable(qOut));

  // A new read is on the bus after the next active edge unless oeN or sleep masks it.
  assert_read_slot_driven_R2: assert property (@(posedge clk) disable iff (!rstN)
    (act && !advLd && sel && weN) ##1 act |=> (qDrive || oeN || sleep));

  // Write, abort and deselect load commands leave their bus slot undriven.
  assert_nonread_slot_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    (act && !advLd && !(sel && weN)) ##1 act |=> !qDrive);

  // With oeN and sleep steady, the drive can only start after an active edge.
  assert_drive_needs_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(qDrive) && $stable(oeN) && $stable(sleep)) |-> $past(!ckeN && !sleep));
endmodule

bind zt_sram zt_sram_check #(.DATA_W(DATA_W)) u_check (
  .clk(clk), .rstN(rstN), .ceN(ceN), .ce2(ce2), .ce2N(ce2N), .advLd(advLd),
  .weN(weN), .ckeN(ckeN), .oeN(oeN), .sleep(sleep), .qDrive(qDrive), .qOut(qOut)
);

// File: tb/zt_sram_test.sv
`timescale 1ns/100ps
module zt_sram_test;
  localparam int AW = 6;
  localparam int L  = 2;
  localparam int LW = 9;
  localparam int DW = L * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ceN = 1'b1, ce2 = 1'b0, ce2N = 1'b1;
  logic          advLd = 1'b0, weN = 1'b1, ckeN = 1'b0, oeN = 1'b0;
  logic          seqLinear = 1'b1, sleep = 1'b0;
  logic [L-1:0]  bwN = '1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] qOut;
  logic          qDrive;

  zt_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW), .BURST_W(2)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .ce2(ce2), .ce2N(ce2N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .ckeN(ckeN), .oeN(oeN),
    .seqLinear(seqLinear), .sleep(sleep), .dIn(dIn), .qOut(qOut), .qDrive(qDrive)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int serial = 0;
  logic [DW-1:0] refMem [DEPTH];

  // Bench pipeline: entry 1 is the newest accepted command, entry 2 owns the bus slot.
  int pKind1 = 0, pKind2 = 0;  // 0 none, 1 read, 2 write
  int pAddr1 = 0, pAddr2 = 0;
  logic [L-1:0]  pMask1 = '0, pMask2 = '0;
  logic [DW-1:0] pData1 = '0, pData2 = '0;
  string pTag1 = "R1", pTag2 = "R1";
  int bLast = 0, bBase = 0, bCnt = 0;

  function automatic logic [DW-1:0] pat(int a, int s);
    logic [31:0] t;
    t = a * 32'h9E37 + s * 32'h79B9 + 32'h1234;
    return t[DW-1:0];
  endfunction

  task automatic checkSlot(string tag, bit expDrive, logic [DW-1:0] expData, bit cmpData);
    vectors++;
    if (qDrive !== expDrive || (cmpData && qOut !== expData)) begin
      miscompares++;
      $display("FAIL %s: qDrive=%0b qOut=%h, expected qDrive=%0b qOut=%h",
               tag, qDrive, qOut, expDrive, expData);
    end
  endtask

  // One clock: ld=1 load command, 0 advance; stall drives ckeN high.
  task automatic tick(input bit ld, input bit sel, input bit wr, input logic [L-1:0] bwn,
                      input int a, input bit stall, input bit slp, input string tag);
    int kind, ea, lo;
    logic [L-1:0]  mk;
    logic [DW-1:0] dv;
    string slotTag;
    @(negedge clk);
    ckeN = stall; sleep = slp; advLd = !ld;
    ceN = !sel; ce2 = sel; ce2N = !sel; weN = !wr; bwN = bwn; addr = AW'(a);
    if (pKind2 == 2) begin
      dIn = pData2;
      for (int i = 0; i < L; i++)
        if (pMask2[i]) refMem[pAddr2][i*LW +: LW] = pData2[i*LW +: LW];
    end else begin
      dIn = pat(63, serial + 7);
    end
    #1;
    slotTag = (stall || slp) ? tag : pTag2;
    checkSlot(slotTag, (pKind2 == 1) && !oeN && !slp, refMem[pAddr2], pKind2 == 1);
    kind = 0; ea = 0; mk = '0; dv = '0;
    if (!stall && !slp) begin
      if (ld) begin
        kind = !sel ? 0 : (wr ? 2 : 1);
        ea = a; bBase = a; bCnt = 0;
      end else begin
        bCnt = (bCnt + 1) % 4;
        lo = seqLinear ? ((bBase % 4) + bCnt) % 4 : ((bBase % 4) ^ bCnt);
        ea = (bBase / 4) * 4 + lo;
        kind = bLast;
      end
      bLast = kind;
      if (kind == 2) begin
        mk = ~bwn; dv = pat(ea, serial); serial++;
      end
    end
    @(posedge clk);
    if (!stall && !slp) begin
      pKind2 = pKind1; pAddr2 = pAddr1; pMask2 = pMask1; pData2 = pData1; pTag2 = pTag1;
      pKind1 = kind;   pAddr1 = ea;     pMask1 = mk;     pData1 = dv;     pTag1 = tag;
    end
  endtask

  task automatic wrCmd(int a, logic [L-1:0] bwn, string tag);
    tick(1, 1, 1, bwn, a, 0, 0, tag);
  endtask
  task automatic rdCmd(int a, string tag);
    tick(1, 1, 0, '1, a, 0, 0, tag);
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(1, 0, 0, '1, 0, 0, 0, tag);
  endtask

  bit done = 0;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 checkSlot("R1", 1'b0, '0, 1'b0);
    idle(2, "R1");

    // Every word, full mask, then read back.
    for (int a = 0; a < DEPTH; a++) wrCmd(a, '0, "R3");
    for (int a = 0; a < DEPTH; a++) rdCmd(a, "R2");
    idle(2, "R6");

    // Back-to-back alternation with no idle edges.
    for (int i = 0; i < DEPTH / 2; i++) begin
      wrCmd(2 * i, '0, "R11");
      rdCmd((2 * i + 7) % DEPTH, "R11");
    end
    // Read right behind a pending write, and one edge later.
    for (int i = 0; i < 8; i++) begin
      wrCmd(i * 5, 2'(i % 3), "R9");
      rdCmd(i * 5, "R9");
      wrCmd(i * 5 + 1, '0, "R9");
      idle(1, "R6");
      rdCmd(i * 5 + 1, "R9");
    end
    idle(2, "R6");

    // Every lane mask, all-high mask is an abort.
    for (int m = 0; m < 4; m++) begin
      wrCmd(40 + m, 2'(m), (m == 3) ? "R4" : "R3");
      idle(2, (m == 3) ? "R4" : "R3");
      rdCmd(40 + m, (m == 3) ? "R4" : "R3");
    end
    idle(2, "R6");

    // Bursts in both orders from every start offset, enables dropped while advancing.
    for (int mode = 0; mode < 2; mode++) begin
      seqLinear = mode[0];
      for (int s = 0; s < 4; s++) begin
        wrCmd(16 + s, '0, "R5");
        for (int k = 0; k < 3; k++) tick(0, 0, 0, 2'(k), 0, 0, 0, "R5");
        rdCmd(16 + s, "R5");
        for (int k = 0; k < 5; k++) tick(0, 0, 1, '0, 0, 0, 0, "R5");
      end
      idle(2, "R6");
      for (int a = 16; a < 20; a++) rdCmd(a, "R5");
      idle(2, "R6");
    end
    seqLinear = 1'b1;

    // Deselect, then advance edges with selects active.
    tick(1, 0, 0, '1, 3, 0, 0, "R6");
    for (int k = 0; k < 4; k++) tick(0, 1, 0, '1, 3, 0, 0, "R6");
    idle(2, "R6");

    // Stalls in a read slot, in a write slot, and an ignored write command.
    rdCmd(7, "R7");
    idle(1, "R7");
    for (int k = 0; k < 3; k++) tick(1, 1, 1, '0, 7, 1, 0, "R7");
    idle(2, "R6");
    wrCmd(9, '0, "R7");
    idle(1, "R7");
    for (int k = 0; k < 3; k++) tick(1, 1, 0, '1, 9, 1, 0, "R7");
    idle(2, "R7");
    rdCmd(9, "R7");
    rdCmd(7, "R7");
    idle(2, "R6");

    // Output enable masks a read slot.
    rdCmd(12, "R8");
    rdCmd(13, "R2");
    idle(1, "R6");
    oeN = 1'b1;
    tick(1, 0, 0, '1, 0, 0, 0, "R8");
    oeN = 1'b0;
    idle(2, "R6");

    // Sleep after deselect edges; commands while asleep are dropped.
    wrCmd(50, '0, "R10");
    idle(3, "R6");
    for (int k = 0; k < 4; k++) tick(1, 1, 1, '0, 50, 0, 1, "R10");
    rdCmd(50, "R10");
    rdCmd(12, "R10");
    idle(3, "R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule